// File: doc/BRIEF.md
# Byte Subtract Execution Unit

This unit carries out one two-operand byte subtract instruction against a 256-byte register file that it holds inside. A sequencer presents an opcode byte and up to two operand bytes and pulses a start strobe. The unit decodes the opcode into one of five addressing forms and resolves the destination and source. It forms the destination minus the source, writes the difference back to the destination and updates the flag register. It then pulses a done output at the cycle count fixed for that form.

The flag register comes out as a port. The byte just written is shown on a result port while done is high. An opcode outside the five subtract forms raises an illegal-opcode pulse and changes nothing. A register's value can be read back through the normal interface by subtracting the immediate 0x00 from it.

Top module: `bsub_exec_unit`

## Requirements
- R1: While reset is held low the flag register, `done_o`, `illegal_o` and every register-file byte are cleared to zero.
- R2: The destination byte is replaced by (destination − source) mod 256, computed as destination plus the two's complement of the source. The source register keeps its value.
- R3: Flag bit 7 (C) is set exactly when the source is larger than the destination as unsigned bytes. Bit 6 (Z) is set when the 8-bit result is zero. Bit 5 (S) equals result bit 7.
- R4: Flag bit 4 (V) is set only when the operands differ in sign and the result's sign equals the source's sign; otherwise it is cleared.
- R5: Flag bit 2 (H) is set when the low nibble of the source exceeds the low nibble of the destination, which means no carry out of bit 3 of the addition. It is cleared otherwise.
- R6: Flag bit 3 (D) is written as 1 by every subtract. Flag bits 1:0 keep their previous value.
- R7: Opcodes 0x22 and 0x23 take the destination working register number in `op1_i[7:4]` and the source number in `op1_i[3:0]`. Working register n sits at address 0xC0+n. 0x22 subtracts that register's value. 0x23 subtracts the byte at the address held in that register.
- R8: Opcodes 0x24, 0x25 and 0x26 take the destination address in `op1_i`. For 0x24 `op2_i` is the source address. For 0x25 `op2_i` names a register holding the source address. For 0x26 `op2_i` is the immediate source value.
- R9: The rising edge that captures the start strobe counts as edge 1. `done_o` is high for exactly one cycle after edge 4 for opcode 0x22 and after edge 6 for the other four forms. `result_o` carries the written byte in that cycle.
- R10: The flag register and the register file change only at the edge that raises `done_o`.
- R11: A start with any opcode outside 0x22–0x26 raises `illegal_o` for one cycle after the capture edge. It produces no done and leaves the flags and registers unchanged.
- R12: A start strobe that arrives while an instruction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an instruction; sampled only when idle |
| opcode_i | input | 8 | Opcode byte |
| op1_i | input | 8 | First operand byte (packed register pair or destination address) |
| op2_i | input | 8 | Second operand byte (source address, pointer register or immediate) |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle pulse for an unsupported opcode |
| result_o | output | 8 | Byte written to the destination, valid while `done_o` is high |
| flags_o | output | 8 | Flag register {C,Z,S,V,D,H,keep,keep} |

## Verification
The result and flags are due in the cycle after edge 4 for the packed working-register form and after edge 6 for every other form. The illegal pulse is due one cycle after the capture edge. Each scenario drives inputs on the falling edge and then counts rising edges from the capture edge. It samples `done_o`, `result_o` and `flags_o` only on falling edges and compares the edge count at which done first appears against the expected 4 or 6. During the busy cycles the flags are sampled on every falling edge to confirm they hold still until done. Expected values come from an unsigned and signed arithmetic model in the bench.

// File: rtl/bsub_pkg.sv
// Package: shared addressing-form encoding and flag bit positions for the
// byte subtract execution unit. Assumes an 8-bit flag register.
package bsub_pkg;

    typedef enum logic [2:0] {
        FORM_WREG  = 3'd0,   // working reg <- working reg
        FORM_WIND  = 3'd1,   // working reg <- @working reg
        FORM_REG   = 3'd2,   // reg <- reg
        FORM_IND   = 3'd3,   // reg <- @reg
        FORM_IMM   = 3'd4,   // reg <- immediate
        FORM_NONE  = 3'd7
    } form_e;

    localparam int FB_C = 7;
    localparam int FB_Z = 6;
    localparam int FB_S = 5;
    localparam int FB_V = 4;
    localparam int FB_D = 3;
    localparam int FB_H = 2;

endpackage

// File: rtl/bsub_decode.sv
// Module: opcode decoder. Maps the opcode byte to an addressing form and the
// number of clock edges the instruction occupies. Purely combinational;
// assumes CYC_SHORT and CYC_LONG are at least 2.
module bsub_decode
    import bsub_pkg::*;
#(
    parameter int CYC_SHORT = 4,
    parameter int CYC_LONG  = 6,
    parameter int CW        = $clog2(CYC_LONG + 1)
) (
    input  logic [7:0]    opcode_i,
    output form_e         form_o,
    output logic          legal_o,
    output logic [CW-1:0] cycles_o
);

    // Select form and duration from the opcode.
    always_comb begin
        legal_o  = 1'b1;
        cycles_o = CW'(CYC_LONG);
        unique case (opcode_i)
            8'h22: begin
                form_o   = FORM_WREG;
                cycles_o = CW'(CYC_SHORT);
            end
            8'h23:   form_o = FORM_WIND;
            8'h24:   form_o = FORM_REG;
            8'h25:   form_o = FORM_IND;
            8'h26:   form_o = FORM_IMM;
            default: begin
                form_o  = FORM_NONE;
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/bsub_regfile.sv
// Module: register file of 2**AW bytes with one write port and three
// combinational reads: direct A, direct B, and the byte addressed by the
// value found at B (for indirect sources). Assumes DW >= AW.
module bsub_regfile #(
    parameter int AW = 8,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] wa_i,
    input  logic [DW-1:0] wd_i,
    input  logic [AW-1:0] ra_i,
    input  logic [AW-1:0] rb_i,
    output logic [DW-1:0] ra_d_o,
    output logic [DW-1:0] rb_d_o,
    output logic [DW-1:0] rind_d_o
);

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[wa_i] <= wd_i;
        end
    end

    // Direct and pointer-chained read ports.
    always_comb begin
        ra_d_o   = mem[ra_i];
        rb_d_o   = mem[rb_i];
        rind_d_o = mem[rb_d_o[AW-1:0]];
    end

endmodule

// File: rtl/bsub_alu.sv
// Module: byte subtractor. Adds the two's complement of the source to the
// destination and derives borrow, zero, sign, overflow and nibble-borrow.
// Combinational; assumes DW >= 4.
module bsub_alu #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] dst_i,
    input  logic [DW-1:0] src_i,
    output logic [DW-1:0] res_o,
    output logic          c_o,
    output logic          z_o,
    output logic          s_o,
    output logic          v_o,
    output logic          h_o
);

    logic [DW:0] full_sum;
    logic [4:0]  low_sum;

    // Two's-complement addition over the full width and over the low nibble.
    always_comb begin
        full_sum = {1'b0, dst_i} + {1'b0, ~src_i} + (DW+1)'(1);
        low_sum  = {1'b0, dst_i[3:0]} + {1'b0, ~src_i[3:0]} + 5'd1;
        res_o    = full_sum[DW-1:0];
        c_o      = ~full_sum[DW];
        h_o      = ~low_sum[4];
        z_o      = (full_sum[DW-1:0] == '0);
        s_o      = full_sum[DW-1];
        v_o      = (dst_i[DW-1] != src_i[DW-1]) && (full_sum[DW-1] == src_i[DW-1]);
    end

    // Borrow flags agree with an unsigned magnitude comparison.
    always_comb begin
        if (!$isunknown({dst_i, src_i})) begin
            AST_BORROW_CMP: assert (c_o == (dst_i < src_i));                    // R3
            AST_NIBBLE_CMP: assert (h_o == (dst_i[3:0] < src_i[3:0]));          // R5
        end
    end

endmodule

// File: rtl/bsub_exec_unit.sv
// Module: top of the byte subtract execution unit. Captures a start with its
// opcode and operands, counts the form's cycle budget, then in the final
// edge writes the difference to the destination and updates the flags.
// Assumes the caller holds no expectation of a start being queued while busy.
module bsub_exec_unit
    import bsub_pkg::*;
#(
    parameter int             AW        = 8,
    parameter int             DW        = 8,
    parameter logic [AW-1:0]  WREG_BASE = 8'hC0,
    parameter int             CYC_SHORT = 4,
    parameter int             CYC_LONG  = 6,
    localparam int            CW        = $clog2(CYC_LONG + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [7:0]    opcode_i,
    input  logic [7:0]    op1_i,
    input  logic [7:0]    op2_i,
    output logic          done_o,
    output logic          illegal_o,
    output logic [DW-1:0] result_o,
    output logic [7:0]    flags_o
);

    form_e         dec_form, form_q;
    logic          dec_legal;
    logic [CW-1:0] dec_cycles, cnt_q;
    logic          busy_q;
    logic [7:0]    op1_q, op2_q;
    logic [AW-1:0] dst_a, ptr_a;
    logic [DW-1:0] dst_d, ptr_d, ind_d, src_d, diff;
    logic          fc, fz, fs, fv, fh;
    logic          finish;
    logic [7:0]    flags_next;

    bsub_decode #(.CYC_SHORT(CYC_SHORT), .CYC_LONG(CYC_LONG), .CW(CW)) dec_i (
        .opcode_i (opcode_i),
        .form_o   (dec_form),
        .legal_o  (dec_legal),
        .cycles_o (dec_cycles)
    );

    bsub_regfile #(.AW(AW), .DW(DW)) rf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (finish),
        .wa_i     (dst_a),
        .wd_i     (diff),
        .ra_i     (dst_a),
        .rb_i     (ptr_a),
        .ra_d_o   (dst_d),
        .rb_d_o   (ptr_d),
        .rind_d_o (ind_d)
    );

    bsub_alu #(.DW(DW)) alu_i (
        .dst_i (dst_d),
        .src_i (src_d),
        .res_o (diff),
        .c_o   (fc),
        .z_o   (fz),
        .s_o   (fs),
        .v_o   (fv),
        .h_o   (fh)
    );

    // Resolve destination address, pointer address and source value per form.
    always_comb begin
        dst_a = AW'(op1_q);
        ptr_a = AW'(op2_q);
        src_d = ptr_d;
        unique case (form_q)
            FORM_WREG, FORM_WIND: begin
                dst_a = WREG_BASE + AW'(op1_q[7:4]);
                ptr_a = WREG_BASE + AW'(op1_q[3:0]);
                src_d = (form_q == FORM_WIND) ? ind_d : ptr_d;
            end
            FORM_IND: src_d = ind_d;
            FORM_IMM: src_d = DW'(op2_q);
            default:  src_d = ptr_d;
        endcase
    end

    // Final-edge strobe and next flag value.
    always_comb begin
        finish           = busy_q && (cnt_q == CW'(1));
        flags_next       = flags_o;
        flags_next[FB_C] = fc;
        flags_next[FB_Z] = fz;
        flags_next[FB_S] = fs;
        flags_next[FB_V] = fv;
        flags_next[FB_D] = 1'b1;
        flags_next[FB_H] = fh;
    end

    // Sequencer: capture, count down, retire with write, flag update and done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            form_q    <= FORM_NONE;
            op1_q     <= '0;
            op2_q     <= '0;
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            result_o  <= '0;
            flags_o   <= '0;
        end else begin
            done_o    <= 1'b0;
            illegal_o <= 1'b0;
            if (!busy_q) begin
                if (start_i && dec_legal) begin
                    busy_q <= 1'b1;
                    cnt_q  <= dec_cycles - CW'(1);
                    form_q <= dec_form;
                    op1_q  <= op1_i;
                    op2_q  <= op2_i;
                end else if (start_i) begin
                    illegal_o <= 1'b1;
                end
            end else if (finish) begin
                busy_q   <= 1'b0;
                done_o   <= 1'b1;
                result_o <= diff;
                flags_o  <= flags_next;
            end else begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                    // R9
    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(flags_o));                                          // R10
    AST_DEC_ALWAYS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> flags_o[FB_D]);                                              // R6
    AST_ILLEGAL_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, illegal_o}));                                         // R11
    AST_ILLEGAL_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(flags_o));                                        // R11

endmodule

// File: tb/bsub_exec_unit_tb_top.sv
// Bench: directed scenarios for the byte subtract execution unit. Each task
// drives on falling edges, samples on falling edges, and checks its results.
module bsub_exec_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic [7:0] op1_i = '0;
    logic [7:0] op2_i = '0;
    logic       done_o, illegal_o;
    logic [7:0] result_o, flags_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;   // 125 MHz

    bsub_exec_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .opcode_i  (opcode_i),
        .op1_i     (op1_i),
        .op2_i     (op2_i),
        .done_o    (done_o),
        .illegal_o (illegal_o),
        .result_o  (result_o),
        .flags_o   (flags_o)
    );

    // Compare one value and report a failure line.
    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Model of the flag register after subtracting s from d.
    function automatic logic [7:0] model_flags(input logic [7:0] d, input logic [7:0] s,
                                               input logic [7:0] prev);
        int sd;
        logic [7:0] r;
        logic [7:0] f;
        r  = d - s;
        sd = int'($signed(d)) - int'($signed(s));
        f    = prev;
        f[7] = (d < s);
        f[6] = (r == 8'h00);
        f[5] = r[7];
        f[4] = (sd > 127) || (sd < -128);
        f[3] = 1'b1;
        f[2] = (d[3:0] < s[3:0]);
        return f;
    endfunction

    // Issue one instruction and wait for done; report edges counted from capture.
    task automatic run_instr(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                             output logic [7:0] res, output logic [7:0] flg, output int edges);
        @(negedge clk);
        start_i = 1'b1; opcode_i = op; op1_i = a; op2_i = b;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        edges = 1;
        while (!done_o && edges < 40) begin
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        res = result_o;
        flg = flags_o;
    endtask

    // Read a register by subtracting immediate zero.
    task automatic read_reg(input logic [7:0] addr, output logic [7:0] v);
        logic [7:0] f;
        int e;
        run_instr(8'h26, addr, 8'h00, v, f, e);
    endtask

    // Force a register to a value with one immediate subtract.
    task automatic set_reg(input logic [7:0] addr, input logic [7:0] v);
        logic [7:0] cur, r, f;
        int e;
        read_reg(addr, cur);
        run_instr(8'h26, addr, cur - v, r, f, e);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 flags after reset", flags_o, 8'h00);
        chk("R1 done after reset", done_o, 0);
        chk("R1 illegal after reset", illegal_o, 0);
        read_reg(8'h01, v);
        chk("R1 reg 0x01 cleared", v, 8'h00);
        read_reg(8'hC5, v);
        chk("R1 reg 0xC5 cleared", v, 8'h00);
    endtask

    task automatic t_imm_examples();
        logic [7:0] r, f, pf;
        int e;
        set_reg(8'h01, 8'h21);
        pf = flags_o;
        run_instr(8'h26, 8'h01, 8'h90, r, f, e);
        chk("R2 0x21-0x90", r, 8'h91);
        chk("R4 flags 0x21-0x90", f, 8'hB8);
        chk("R3 model 0x21-0x90", f, model_flags(8'h21, 8'h90, pf));
        chk("R9 immediate form edges", e, 6);
        set_reg(8'h01, 8'h21);
        run_instr(8'h26, 8'h01, 8'h65, r, f, e);
        chk("R2 0x21-0x65", r, 8'hBC);
        chk("R5 flags 0x21-0x65", f, 8'hAC);
        read_reg(8'h01, r);
        chk("R8 immediate dest holds result", r, 8'hBC);
    endtask

    task automatic t_wreg();
        logic [7:0] r, f;
        int e;
        set_reg(8'hC1, 8'h12);
        set_reg(8'hC2, 8'h03);
        run_instr(8'h22, 8'h12, 8'h00, r, f, e);
        chk("R7 wreg 0x12-0x03", r, 8'h0F);
        chk("R6 flags wreg", f, 8'h0C);
        chk("R9 wreg form edges", e, 4);
        read_reg(8'hC2, r);
        chk("R2 source reg unchanged", r, 8'h03);
        read_reg(8'hC1, r);
        chk("R7 dest at 0xC1", r, 8'h0F);
    endtask

    task automatic t_wind();
        logic [7:0] r, f;
        int e;
        set_reg(8'hC1, 8'h12);
        set_reg(8'hC2, 8'h03);
        set_reg(8'h03, 8'h0A);
        run_instr(8'h23, 8'h12, 8'h00, r, f, e);
        chk("R7 wind 0x12-@0x03", r, 8'h08);
        chk("R9 wind form edges", e, 6);
    endtask

    task automatic t_reg_forms();
        logic [7:0] r, f;
        int e;
        set_reg(8'h01, 8'h21);
        set_reg(8'h02, 8'h03);
        run_instr(8'h24, 8'h01, 8'h02, r, f, e);
        chk("R8 reg form 0x21-0x03", r, 8'h1E);
        chk("R9 reg form edges", e, 6);
        read_reg(8'h02, r);
        chk("R2 reg source unchanged", r, 8'h03);
        set_reg(8'h01, 8'h21);
        set_reg(8'h03, 8'h0A);
        run_instr(8'h25, 8'h01, 8'h02, r, f, e);
        chk("R8 ind form 0x21-@0x03", r, 8'h17);
        chk("R9 ind form edges", e, 6);
    endtask

    task automatic t_flag_corners();
        logic [7:0] r, f, pf;
        int e;
        set_reg(8'h05, 8'h80);
        run_instr(8'h26, 8'h05, 8'h80, r, f, e);
        chk("R3 zero result", r, 8'h00);
        chk("R3 zero flag", f, 8'h48);
        set_reg(8'h05, 8'h7F);
        pf = flags_o;
        run_instr(8'h26, 8'h05, 8'hFF, r, f, e);
        chk("R4 positive overflow value", r, 8'h80);
        chk("R4 positive overflow flags", f, model_flags(8'h7F, 8'hFF, pf));
        set_reg(8'h05, 8'h80);
        run_instr(8'h26, 8'h05, 8'h01, r, f, e);
        chk("R4 negative overflow value", r, 8'h7F);
        chk("R4 negative overflow flags", f, 8'h1C);
    endtask

    task automatic t_flags_hold();
        logic [7:0] pf;
        int n;
        set_reg(8'h01, 8'h00);
        set_reg(8'h02, 8'h03);
        set_reg(8'h03, 8'h05);
        pf = flags_o;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'h25; op1_i = 8'h01; op2_i = 8'h02;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        n = 1;
        while (!done_o && n < 40) begin
            chk("R10 flags still during busy", flags_o, pf);
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        chk("R10 done edge", n, 6);
        chk("R10 flags at done", flags_o, model_flags(8'h00, 8'h05, pf));
        chk("R9 result at done", result_o, 8'hFB);
        @(negedge clk);
        chk("R9 done lasts one cycle", done_o, 0);
    endtask

    task automatic t_illegal();
        logic [7:0] pf, r;
        set_reg(8'h01, 8'h44);
        pf = flags_o;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'h27; op1_i = 8'h01; op2_i = 8'h05;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        chk("R11 illegal pulse", illegal_o, 1);
        chk("R11 no done", done_o, 0);
        @(negedge clk);
        chk("R11 illegal one cycle", illegal_o, 0);
        chk("R11 no late done", done_o, 0);
        chk("R11 flags unchanged", flags_o, pf);
        read_reg(8'h01, r);
        chk("R11 register unchanged", r, 8'h44);
    endtask

    task automatic t_busy_start();
        logic [7:0] r;
        int dones = 0;
        set_reg(8'h01, 8'h10);
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'h26; op1_i = 8'h01; op2_i = 8'h01;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        start_i = 1'b1; opcode_i = 8'h26; op1_i = 8'h01; op2_i = 8'h0F;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (done_o) begin
                dones++;
                chk("R12 result of first start", result_o, 8'h0F);
            end
            @(negedge clk);
        end
        chk("R12 single completion", dones, 1);
        read_reg(8'h01, r);
        chk("R12 register after ignored start", r, 8'h0F);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_imm_examples();
        t_wreg();
        t_wind();
        t_reg_forms();
        t_flag_corners();
        t_flags_hold();
        t_illegal();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule